// File: doc/BRIEF.md
# Four-Channel Match-Compare System Timer

This block is a memory-mapped timer for an operating system. A single 32-bit up-counter advances by one on every clock cycle in which the `tick` input is high. Four match registers are each compared against that counter. When the counter holds a channel's match value during a tick cycle, that channel's status bit is raised. The status bit drives the channel's interrupt output only while the channel's interrupt enable is set.

Software reaches the block over a simple single-cycle register port with address, write data, write strobe, read strobe and read data. It can load the counter, arm any channel at a chosen future count, and clear status bits by writing ones to them. The same register space holds a watchdog enable. Once software sets that enable, a match on the last channel (channel 3) produces a one-cycle reset request. The enable cannot be cleared afterwards except by a hardware reset.

Top module: `os_match_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `wdt_rst` is 0.
- R2: The counter (offset 0x10) adds one at each clock edge where `tick` is high and holds otherwise; 0xFFFFFFFF advances to 0x00000000.
- R3: Writing offset 0x10 loads the counter with `wdata`; in a cycle with both a counter write and a tick, the written value wins.
- R4: Match registers for channels 0..3 sit at offsets 0x00, 0x04, 0x08, 0x0C and read back what was written.
- R5: Status bit n (offset 0x14, bit n) is set at the edge ending a tick cycle in which the counter equals match register n, whatever the interrupt enable holds.
- R6: A write to offset 0x14 clears each status bit whose `wdata` bit is 1 and leaves bits written 0 unchanged; if a clear and a new match of the same channel fall in one cycle, the bit stays set.
- R7: `irq[n]` is status bit n AND interrupt-enable bit n (offset 0x1C, bits 3:0).
- R8: Watchdog enable is bit 0 of offset 0x18; writing 1 sets it and it then ignores writes of 0 until reset.
- R9: With the watchdog enable set, a channel-3 match raises `wdt_rst` for exactly one cycle, in the same cycle that status bit 3 becomes visible; with it clear, no pulse is produced.
- R10: Offsets 0x20 and above, and any address with bits 1:0 nonzero, read as zero and ignore writes; `rdata` is zero while `rd` is low.
- R11: A match is caught only if the counter actually holds the match value during a tick; loading the counter past that value skips the event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable, already in this clock domain |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe; read data is valid in the same cycle |
| rdata | output | 32 | Read data, zero when not reading |
| irq | output | 4 | Per-channel interrupt, level |
| wdt_rst | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
The assertions assume that `tick` and the bus strobes are synchronous to `clk` and free of X after reset. They also assume that a read strobe samples `rdata` combinationally within the same cycle. The bench meets this by driving every input on the falling edge and sampling half a period later. It holds `tick` low during reset and during register setup, so counter values stay predictable. Ticks are issued only in counted bursts, which lets the bench place each match edge and each watchdog pulse on a known cycle.

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int NCH    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DW-1:0]     rdata,
  output logic [NCH-1:0]    irq,
  output logic              wdt_rst
);
  localparam int IW      = ADDR_W - 2;
  localparam int W_CNT   = NCH;
  localparam int W_STAT  = NCH + 1;
  localparam int W_WDEN  = NCH + 2;
  localparam int W_IE    = NCH + 3;
  localparam int NWORDS  = NCH + 4;
  localparam int WDT_CH  = NCH - 1;

  logic [DW-1:0]  match_q [NCH];
  logic [DW-1:0]  cnt_q;
  logic [NCH-1:0] stat_q, ie_q, hit, clr;
  logic           wden_q;

  logic [IW-1:0] widx;
  logic          word_ok;
  assign widx    = addr[ADDR_W-1:2];
  assign word_ok = (addr[1:0] == 2'b00) && (int'(widx) < NWORDS);

  logic wr_cnt, wr_stat, wr_wden, wr_ie;
  assign wr_cnt  = wr && word_ok && (widx == IW'(W_CNT));
  assign wr_stat = wr && word_ok && (widx == IW'(W_STAT));
  assign wr_wden = wr && word_ok && (widx == IW'(W_WDEN));
  assign wr_ie   = wr && word_ok && (widx == IW'(W_IE));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rst_n)
          match_q[g] <= '0;
        else if (wr && word_ok && (widx == IW'(g)))
          match_q[g] <= wdata;
      end
      assign hit[g] = tick && (cnt_q == match_q[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign clr = wr_stat ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ie_q    <= '0;
      wden_q  <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~clr) | hit;
      if (wr_ie) ie_q <= wdata[NCH-1:0];
      if (wr_wden && wdata[0]) wden_q <= 1'b1;
      wdt_rst <= hit[WDT_CH] && wden_q;
    end
  end

  assign irq = stat_q & ie_q;

  always_comb begin
    rdata = '0;
    if (rd && word_ok) begin
      if (int'(widx) < NCH)          rdata = match_q[widx[$clog2(NCH)-1:0]];
      else if (widx == IW'(W_CNT))   rdata = cnt_q;
      else if (widx == IW'(W_STAT))  rdata = DW'(stat_q);
      else if (widx == IW'(W_WDEN))  rdata = DW'(wden_q);
      else                           rdata = DW'(ie_q);
    end
  end
endmodule

module os_match_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int NCH    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic              wr,
  input logic              rd,
  input logic [DW-1:0]     rdata,
  input logic [DW-1:0]     cnt,
  input logic [NCH-1:0]    stat,
  input logic              wden,
  input logic              wdt_rst
);
  localparam int NBYTES = 4 * (NCH + 4);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  logic wcnt, wst, unmapped;
  assign wcnt     = wr && (int'(addr) == 4 * NCH);
  assign wst      = wr && (int'(addr) == 4 * NCH + 4);
  assign unmapped = (addr[1:0] != 2'b00) || (int'(addr) >= NBYTES);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (cnt == '0 && stat == '0 && !wden && !wdt_rst));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(tick) && !$past(wcnt)) |-> cnt == $past(cnt) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(tick) && !$past(wcnt)) |-> cnt == $past(cnt));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wcnt)) |-> cnt == $past(wdata));
  // R6
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(wst)) |-> ((stat & $past(stat)) == $past(stat)));
  // R8
  wden_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wden)) |-> wden);
  // R9
  wdt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (live && $past(tick) && $past(wden)));
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && unmapped) |-> rdata == '0);
endmodule

bind os_match_timer os_match_timer_chk #(.ADDR_W(ADDR_W), .DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata), .wr(wr),
  .rd(rd), .rdata(rdata), .cnt(cnt_q), .stat(stat_q), .wden(wden_q),
  .wdt_rst(wdt_rst)
);

// File: tb/tb_os_match_timer.sv
module tb_os_match_timer;
  logic        clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  irq;
  logic        wdt_rst;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  os_match_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .irq(irq), .wdt_rst(wdt_rst));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    rd = 1; addr = a; #1; d = rdata; rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  localparam int NV = 14;
  localparam logic        V_WR [NV] = '{1,1,1,1,0,0,0,0,1,0,1,0,1,0};
  localparam logic [7:0]  V_A  [NV] = '{8'h00,8'h04,8'h08,8'h0C,8'h00,8'h04,8'h08,8'h0C,
                                        8'h1C,8'h1C,8'h10,8'h10,8'h1C,8'h1C};
  localparam logic [31:0] V_D  [NV] = '{32'h11111111,32'h22222222,32'h33333333,32'h44444444,
                                        32'h11111111,32'h22222222,32'h33333333,32'h44444444,
                                        32'hFFFFFFF5,32'h5,32'h1234,32'h1234,32'h0,32'h0};

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 32; a += 4) begin
      rreg(8'(a), v); check("R1", v, 0);
    end
    check("R1 irq", 32'(irq), 0);
    check("R1 wdt", 32'(wdt_rst), 0);

    // R4 match regs, R7 enable width, R3 counter load
    for (int i = 0; i < NV; i++) begin
      if (V_WR[i]) wreg(V_A[i], V_D[i]);
      else begin rreg(V_A[i], v); check("R4/R7/R3 vector", v, V_D[i]); end
    end

    // R2 counting and holding
    wreg(8'h10, 32'd5);
    ticks(3);
    rreg(8'h10, v); check("R2 count", v, 32'd8);
    repeat (2) @(negedge clk);
    rreg(8'h10, v); check("R2 hold", v, 32'd8);
    wreg(8'h10, 32'hFFFFFFFF);
    ticks(1);
    rreg(8'h10, v); check("R2 wrap", v, 32'd0);

    // R3 write beats tick
    @(negedge clk); addr = 8'h10; wdata = 32'd100; wr = 1; tick = 1;
    @(negedge clk); wr = 0; tick = 0;
    rreg(8'h10, v); check("R3 priority", v, 32'd100);

    // R5 match with enable clear, R7 gating
    wreg(8'h04, 32'd10);
    wreg(8'h10, 32'd8);
    wreg(8'h14, 32'hF);
    ticks(2);
    rreg(8'h14, v); check("R5 before match", v & 32'h2, 0);
    ticks(1);
    rreg(8'h14, v); check("R5 match", v & 32'h2, 32'h2);
    check("R7 gated off", 32'(irq), 0);
    wreg(8'h1C, 32'h2);
    check("R7 gated on", 32'(irq), 32'h2);

    // R6 write-one-to-clear
    wreg(8'h14, 32'h0);
    rreg(8'h14, v); check("R6 zero write", v & 32'h2, 32'h2);
    wreg(8'h14, 32'h2);
    rreg(8'h14, v); check("R6 clear", v & 32'h2, 0);
    check("R6 irq drop", 32'(irq), 0);

    // R6 set beats clear
    wreg(8'h00, 32'd20);
    wreg(8'h10, 32'd20);
    wreg(8'h14, 32'hF);
    @(negedge clk); addr = 8'h14; wdata = 32'h1; wr = 1; tick = 1;
    @(negedge clk); wr = 0; tick = 0;
    rreg(8'h14, v); check("R6 set wins", v & 32'h1, 32'h1);

    // R11 skipped match
    wreg(8'h08, 32'd50);
    wreg(8'h10, 32'd45);
    wreg(8'h14, 32'hF);
    ticks(2);
    wreg(8'h10, 32'd60);
    ticks(5);
    rreg(8'h14, v); check("R11 skipped", v & 32'h4, 0);

    // R10 unmapped access
    wreg(8'h20, 32'hDEADBEEF);
    wreg(8'h01, 32'hDEADBEEF);
    rreg(8'h20, v); check("R10 read high", v, 0);
    rreg(8'h01, v); check("R10 read misaligned", v, 0);
    rreg(8'h00, v); check("R10 no side effect", v, 32'd20);
    addr = 8'h00; #1; check("R10 rd low", rdata, 0);

    // R9 no pulse without enable
    wreg(8'h0C, 32'd200);
    wreg(8'h10, 32'd200);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check("R9 disabled", 32'(wdt_rst), 0);

    // R8 sticky enable
    wreg(8'h18, 32'h1);
    rreg(8'h18, v); check("R8 set", v, 1);
    wreg(8'h18, 32'h0);
    rreg(8'h18, v); check("R8 sticky", v, 1);

    // R9 pulse
    wreg(8'h10, 32'd200);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    check("R9 pulse", 32'(wdt_rst), 1);
    @(negedge clk);
    check("R9 one cycle", 32'(wdt_rst), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule